// File: doc/BRIEF.md
# Multi-Master I2C Master Engine

This block is the master side of an I2C controller that shares its two wires with other masters. Software-style control inputs set a master-enable bit together with a transfer direction and a 7-bit target address. Setting the enable bit while the engine is idle makes it issue a START and send the address byte. It then moves data bytes in the chosen direction until the transfer ends, and finishes with a STOP. The lines are open-drain: the block only requests a low level on SCL or SDA and reads the wire levels back.

In transmit, each data byte is taken from `tx_data` when the previous byte completes, and the acknowledge seen on the bus is reported with a `byte_done` pulse. In receive, every byte is presented on `rx_data`, and the block acknowledges it unless `last_byte` marked it as the final one. A no-acknowledge from the target, or clearing the enable bit, ends the transfer. The STOP always waits until the byte in flight has finished, including its acknowledge bit. If another master wins the bus, the block drops both lines at once, records the loss and goes passive without a STOP.

With `pec_en` set, the final received byte is treated as a packet error code. A CRC-8 runs over every byte of the transfer, starting with the address byte. After that byte has gone through the CRC, the error flag shows whether the remainder is zero. Reset does not clear this flag.

Top module: `i2cm_top`

## Requirements
- R1: Writing `ctl_en`=1 with `ctl_wr` while idle sets `master_en` and produces a START: SDA falls while SCL is released. After SCL falls, the address byte is shifted out MSB first.
- R2: The address byte on the wire is `{ctl_addr[6:0], ctl_dir}`: the direction bit is bit 0 and is sent last. `dir_q` holds the direction.
- R3: With direction 0, the data bytes on the bus are successive `tx_data` values, each sampled as the previous byte completes. With direction 1, every received byte appears on `rx_data` with a `byte_done` pulse.
- R4: In receive, the block drives ACK (SDA low) in the 9th bit of each data byte and drives NACK (SDA released) for a byte whose `last_byte` was high when that byte began. STOP then follows.
- R5: A no-acknowledge on a byte the block transmitted sets `nak_flag`, clears `master_en` and is followed by STOP. No further byte is started.
- R6: Clearing `master_en` (`ctl_wr` with `ctl_en`=0) takes effect in the next cycle. The byte in progress still completes through its acknowledge bit, and only then does STOP follow.
- R7: When the block releases SDA as a transmitter while SCL reads high and SDA reads low, `arb_lost` is set and `master_en` is cleared. On the same clock edge both line drives are released. No STOP is produced afterwards.
- R8: When `pec_en` is set in receive, the final byte is a check byte. The CRC-8 (x^8+x^2+x+1, initial 0, MSB first) runs over the address byte and all data bytes including that check byte. `crc_err` becomes 0 if the result is zero and 1 otherwise. It keeps its value through transfers without a check byte.
- R9: Reset clears `master_en`, `dir_q` and both line drives and leaves `crc_err` unchanged.
- R10: One bit lasts 4*(`clk_div`+1) clocks in four quarter phases. SDA is held stable while SCL is released, except during START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Master-enable value written |
| ctl_dir | input | 1 | Direction value written (1 = receive) |
| ctl_addr | input | 7 | Target address written |
| clk_div | input | DIV_W | Quarter-bit period minus one, in clocks |
| tx_data | input | 8 | Next byte to transmit |
| last_byte | input | 1 | Next received byte is the final one |
| pec_en | input | 1 | Final received byte is a check byte |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| scl_lo | output | 1 | Pull SCL low |
| sda_lo | output | 1 | Pull SDA low |
| master_en | output | 1 | Master-enable bit |
| dir_q | output | 1 | Direction bit |
| byte_done | output | 1 | One-cycle pulse after each byte and its acknowledge |
| rx_data | output | 8 | Byte seen on the bus in the last completed byte |
| ack_rcvd | output | 1 | Acknowledge level of the last completed byte (1 = ACK) |
| nak_flag | output | 1 | Target answered no-acknowledge |
| arb_lost | output | 1 | Bus lost to another master |
| crc_err | output | 1 | Last check byte did not match |

## Verification
The hardest situations to reach from the ports are a lost arbitration and a clear of the enable bit in the middle of a byte. Both must land on a precise bit of the transfer. The bench models the target on the shared wires and keeps its own bit and byte counters. From those counters it times a rival master that holds SDA low at an address bit that is 1, and it times the enable clear at bit 3 of the first data byte. Check-byte outcomes are set up by computing the CRC in the bench and corrupting one bit on purpose.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_BITS = 8;
    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_STOP
    } bus_st_e;

    // Role of the byte currently on the wire
    typedef struct packed {
        logic rx;    // data bits come from the target
        logic last;  // receive: answer with NACK
    } byte_ctx_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
        logic [7:0] r;
        r = crc ^ din;
        for (int i = 0; i < BYTE_BITS; i++) begin
            r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/i2cm_clkdiv.sv
module i2cm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);
endmodule

// File: rtl/i2cm_pec.sv
module i2cm_pec (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd,
    input  logic       chk,
    input  logic [7:0] din,
    output logic       crc_err
);
    import i2cm_pkg::*;

    logic [7:0] crc_q;
    logic [7:0] crc_nx;

    assign crc_nx = crc8_step(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '0;
        end else if (upd) begin
            crc_q <= crc_nx;
        end
    end

    // Deliberately outside reset: the flag survives it
    always_ff @(posedge clk) begin
        if (chk) begin
            crc_err <= (crc_nx != 8'h00);
        end
    end
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic             ctl_dir,
    input  logic [6:0]       ctl_addr,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [7:0]       tx_data,
    input  logic             last_byte,
    input  logic             pec_en,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_lo,
    output logic             sda_lo,
    output logic             master_en,
    output logic             dir_q,
    output logic             byte_done,
    output logic [7:0]       rx_data,
    output logic             ack_rcvd,
    output logic             nak_flag,
    output logic             arb_lost,
    output logic             crc_err
);
    import i2cm_pkg::*;

    localparam logic [3:0] ACK_IDX = 4'(BYTE_BITS);

    bus_st_e    st;
    logic [1:0] ph;
    logic [3:0] bi;
    logic [7:0] sh;
    logic [7:0] rsh;
    logic [7:0] byte_q;
    logic [6:0] addr_q;
    logic       ack_seen;
    byte_ctx_t  ctx;

    logic tick, own_one, arb_hit, start_go, byte_end, pec_chk;

    i2cm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .run (st != ST_IDLE),
        .div (clk_div),
        .tick(tick)
    );

    assign start_go = ctl_wr && ctl_en && (st == ST_IDLE);
    assign byte_end = tick && (st == ST_BIT) && (ph == 2'd3) && (bi == ACK_IDX);
    assign pec_chk  = byte_end && ctx.rx && ctx.last && pec_en;

    i2cm_pec u_pec (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_go),
        .upd    (byte_end),
        .chk    (pec_chk),
        .din    (ctx.rx ? rsh : byte_q),
        .crc_err(crc_err)
    );

    // Line drives follow the state and phase registers
    always_comb begin
        scl_lo  = 1'b0;
        sda_lo  = 1'b0;
        own_one = 1'b0;
        case (st)
            ST_START: begin
                sda_lo = (ph != 2'd0);
                scl_lo = (ph == 2'd3);
            end
            ST_BIT: begin
                scl_lo = !ph[1];
                if (bi < ACK_IDX) begin
                    sda_lo  = !ctx.rx && !sh[7];
                    own_one = !ctx.rx && sh[7];
                end else begin
                    sda_lo  = ctx.rx && !ctx.last;
                    own_one = ctx.rx && ctx.last;
                end
            end
            ST_STOP: begin
                scl_lo = (ph == 2'd0);
                sda_lo = !ph[1];
            end
            default: ;
        endcase
    end

    assign arb_hit = own_one && !scl_lo && scl_in && !sda_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= '0;
            bi        <= '0;
            sh        <= '0;
            rsh       <= '0;
            byte_q    <= '0;
            addr_q    <= '0;
            ack_seen  <= 1'b0;
            ctx       <= '0;
            master_en <= 1'b0;
            dir_q     <= 1'b0;
            byte_done <= 1'b0;
            rx_data   <= '0;
            ack_rcvd  <= 1'b0;
            nak_flag  <= 1'b0;
            arb_lost  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (ctl_wr && !ctl_en) begin
                master_en <= 1'b0;
            end else if (start_go) begin
                master_en <= 1'b1;
                dir_q     <= ctl_dir;
                addr_q    <= ctl_addr;
                nak_flag  <= 1'b0;
                arb_lost  <= 1'b0;
                st        <= ST_START;
                ph        <= '0;
            end

            if (arb_hit) begin
                arb_lost  <= 1'b1;
                master_en <= 1'b0;
                st        <= ST_IDLE;
                ph        <= '0;
            end else if (tick) begin
                ph <= ph + 1'b1;
                case (st)
                    ST_START: begin
                        if (ph == 2'd3) begin
                            st     <= ST_BIT;
                            bi     <= '0;
                            sh     <= {addr_q, dir_q};
                            byte_q <= {addr_q, dir_q};
                            ctx    <= '{rx: 1'b0, last: 1'b0};
                        end
                    end
                    ST_BIT: begin
                        if (ph == 2'd2) begin
                            if (bi < ACK_IDX) rsh <= {rsh[6:0], sda_in};
                            else              ack_seen <= !sda_in;
                        end
                        if (ph == 2'd3) begin
                            if (bi < ACK_IDX) begin
                                bi <= bi + 1'b1;
                                sh <= sh << 1;
                            end else begin
                                byte_done <= 1'b1;
                                rx_data   <= rsh;
                                ack_rcvd  <= ack_seen;
                                if (!ctx.rx && !ack_seen) begin
                                    nak_flag  <= 1'b1;
                                    master_en <= 1'b0;
                                    st        <= ST_STOP;
                                end else if (ctx.rx && ctx.last) begin
                                    master_en <= 1'b0;
                                    st        <= ST_STOP;
                                end else if (!master_en) begin
                                    st <= ST_STOP;
                                end else begin
                                    bi     <= '0;
                                    sh     <= tx_data;
                                    byte_q <= tx_data;
                                    ctx    <= '{rx: dir_q, last: last_byte};
                                end
                            end
                        end
                    end
                    ST_STOP: begin
                        if (ph == 2'd3) st <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
    input logic               clk,
    input logic               rst,
    input i2cm_pkg::bus_st_e  st,
    input logic [3:0]         bi,
    input logic               scl_lo,
    input logic               sda_lo,
    input logic               master_en,
    input logic               arb_lost,
    input logic               nak_flag
);
    import i2cm_pkg::*;

    // R7: on the loss edge both lines are free and the enable bit is gone
    a_r7_release_now: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> (!scl_lo && !sda_lo && !master_en && st == ST_IDLE));

    // R5: a target NAK clears the enable bit and heads for STOP
    a_r5_nak_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(nak_flag) |-> (!master_en && st == ST_STOP));

    // R6: STOP is entered only at the end of an acknowledge bit
    a_r6_stop_after_ack: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP && $past(st) != ST_STOP) |-> ($past(st) == ST_BIT && $past(bi) == 4'd8));

    // R10: no SDA change while SCL is released inside a bit
    a_r10_sda_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT && $past(st) == ST_BIT && !scl_lo && !$past(scl_lo)) |-> $stable(sda_lo));

    // R9: an idle engine drives neither line
    a_r9_idle_free: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (!scl_lo && !sda_lo));
endmodule

bind i2cm_top i2cm_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .bi       (bi),
    .scl_lo   (scl_lo),
    .sda_lo   (sda_lo),
    .master_en(master_en),
    .arb_lost (arb_lost),
    .nak_flag (nak_flag)
);

// File: tb/sim_i2cm_top.sv
`timescale 1ns/1ps
module sim_i2cm_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, ctl_wr, ctl_en, ctl_dir, last_byte, pec_en;
    logic [6:0] ctl_addr;
    logic [7:0] clk_div, tx_data, rx_data;
    logic       scl_lo, sda_lo, master_en, dir_q, byte_done, ack_rcvd;
    logic       nak_flag, arb_lost, crc_err;
    logic       s_lo = 1'b0;
    logic       rival_lo = 1'b0;
    logic       scl_bus, sda_bus;

    assign scl_bus = !scl_lo;
    assign sda_bus = !(sda_lo || s_lo || rival_lo);

    i2cm_top #(.DIV_W(8)) u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_dir(ctl_dir),
        .ctl_addr(ctl_addr), .clk_div(clk_div), .tx_data(tx_data), .last_byte(last_byte),
        .pec_en(pec_en), .scl_in(scl_bus), .sda_in(sda_bus), .scl_lo(scl_lo), .sda_lo(sda_lo),
        .master_en(master_en), .dir_q(dir_q), .byte_done(byte_done), .rx_data(rx_data),
        .ack_rcvd(ack_rcvd), .nak_flag(nak_flag), .arb_lost(arb_lost), .crc_err(crc_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=finished", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Bench model of the addressed target on the shared wires
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    int         bitn = -2, byten = 0, got_n = 0, starts = 0, stops = 0, nak_at = 99;
    logic [7:0] sr;
    logic       slv_rw = 1'b0, quiet = 1'b0;
    logic [7:0] got [0:15];
    logic       mack [0:15];
    logic [7:0] rdat [0:15];

    always @(negedge clk) begin
        if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
            starts++; bitn = -1; byten = 0; got_n = 0; quiet = 1'b0; s_lo = 1'b0;
        end else if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
            stops++; bitn = -2; s_lo = 1'b0;
        end else if (bitn >= -1) begin
            if (!prev_scl && scl_bus) begin
                if (bitn >= 0 && bitn < 8) begin
                    sr = {sr[6:0], sda_bus};
                    if (bitn == 7) begin
                        got[byten] = sr; got_n = byten + 1;
                        if (byten == 0) slv_rw = sr[0];
                    end
                end else if (bitn == 8) begin
                    mack[byten] = !sda_bus;
                    if (slv_rw && byten > 0 && sda_bus) quiet = 1'b1;
                end
            end
            if (prev_scl && !scl_bus) begin
                bitn++;
                if (bitn == 9) begin bitn = 0; byten++; end
                s_lo = 1'b0;
                if (bitn == 8) begin
                    if (byten == 0 || !slv_rw) s_lo = (byten != nak_at);
                end else if (bitn >= 0 && byten >= 1 && slv_rw && !quiet) begin
                    s_lo = !rdat[byten-1][7-bitn];
                end
            end
        end
        prev_scl = scl_bus;
        prev_sda = sda_bus;
    end

    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    logic [7:0] dat [0:15];
    logic [7:0] rxb [0:15];
    int xs0, xt0;

    task automatic start_xfer(input logic [6:0] a, input logic d);
        @(negedge clk); ctl_wr = 1'b1; ctl_en = 1'b1; ctl_dir = d; ctl_addr = a;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic run_xfer(input logic [6:0] a, input logic d, input int n, input int nk,
                            input logic pe, input logic bad, input logic [7:0] seed);
        logic [7:0] c;
        int k = 0;
        int guard = 0;
        for (int i = 0; i < n; i++) dat[i] = seed + 8'(i * 37);
        if (pe) begin
            c = crc_ref(8'h00, {a, d});
            for (int i = 0; i < n - 1; i++) c = crc_ref(c, dat[i]);
            dat[n-1] = bad ? (c ^ 8'h01) : c;
        end
        for (int i = 0; i < n; i++) rdat[i] = dat[i];
        nak_at = nk; xs0 = stops; xt0 = starts;
        tx_data = dat[0]; last_byte = (n == 1); pec_en = pe;
        start_xfer(a, d);
        while (stops == xs0 && guard < 20000) begin
            @(negedge clk); guard++; ctl_wr = 1'b0;
            if (byte_done) begin
                rxb[k] = rx_data;
                if (k + 1 < n) tx_data = dat[k+1];
                last_byte = (k + 2 == n);
                if (!d && k == n - 1) begin ctl_wr = 1'b1; ctl_en = 1'b0; end
                k++;
            end
        end
        ctl_wr = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    typedef struct packed {
        logic [6:0] a; logic d; logic [3:0] n; logic [3:0] nk;
        logic pe; logic bad; logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{7'h2A, 1'b0, 4'd3, 4'd15, 1'b0, 1'b0, 8'h11},
        '{7'h55, 1'b1, 4'd4, 4'd15, 1'b0, 1'b0, 8'hC3},
        '{7'h7F, 1'b1, 4'd3, 4'd15, 1'b1, 1'b0, 8'h05},
        '{7'h10, 1'b1, 4'd3, 4'd15, 1'b1, 1'b1, 8'h9A},
        '{7'h33, 1'b0, 4'd4, 4'd2,  1'b0, 1'b0, 8'h40},
        '{7'h61, 1'b1, 4'd1, 4'd15, 1'b1, 1'b0, 8'h00},
        '{7'h01, 1'b0, 4'd1, 4'd15, 1'b0, 1'b0, 8'hFF}
    };

    initial begin
        logic exp_err;
        logic have_exp = 1'b0;
        int cnt, guard, s0;
        rst = 1'b1; ctl_wr = 1'b0; ctl_en = 1'b0; ctl_dir = 1'b0; ctl_addr = '0;
        clk_div = 8'd2; tx_data = '0; last_byte = 1'b0; pec_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(!master_en && !dir_q, "R9 reset clears enable and direction", {master_en, dir_q}, 0);
        chk(!scl_lo && !sda_lo, "R9 reset frees lines", {scl_lo, sda_lo}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        for (int v = 0; v < 7; v++) begin
            vec_t t = VECS[v];
            run_xfer(t.a, t.d, int'(t.n), int'(t.nk), t.pe, t.bad, t.seed);
            chk(starts == xt0 + 1, "R1 one START", starts - xt0, 1);
            chk(got[0] == {t.a, t.d}, "R2 address byte", got[0], {t.a, t.d});
            if (t.nk != 4'd15) begin
                chk(nak_flag, "R5 nak flag", nak_flag, 1);
                chk(!master_en, "R5 enable cleared", master_en, 0);
                chk(got_n == int'(t.nk) + 1, "R5 no byte after NAK", got_n, int'(t.nk) + 1);
                chk(stops == xs0 + 1, "R5 STOP issued", stops - xs0, 1);
            end else if (!t.d) begin
                chk(got_n == int'(t.n) + 1, "R6 STOP after final byte", got_n, int'(t.n) + 1);
                for (int i = 0; i < int'(t.n); i++)
                    chk(got[i+1] == dat[i], "R3 written byte", got[i+1], dat[i]);
                chk(!nak_flag, "R3 writes acknowledged", nak_flag, 0);
            end else begin
                for (int i = 0; i < int'(t.n); i++) begin
                    chk(rxb[i+1] == dat[i], "R3 read byte", rxb[i+1], dat[i]);
                    chk(mack[i+1] == (i < int'(t.n) - 1), "R4 ACK/NACK pattern", mack[i+1], (i < int'(t.n) - 1));
                end
                chk(stops == xs0 + 1, "R4 STOP after NACK", stops - xs0, 1);
            end
            if (t.pe) begin
                chk(crc_err == t.bad, "R8 check byte result", crc_err, t.bad);
                exp_err = t.bad; have_exp = 1'b1;
            end else if (have_exp) begin
                chk(crc_err == exp_err, "R8 flag held without check byte", crc_err, exp_err);
            end
            chk(!master_en && !scl_lo && !sda_lo, "R6 idle after STOP", {master_en, scl_lo, sda_lo}, 0);
        end

        // R10 bit period and R6 clear in mid byte
        nak_at = 99; tx_data = 8'hA5; last_byte = 1'b0; pec_en = 1'b0; s0 = stops;
        start_xfer(7'h22, 1'b0);
        guard = 0;
        while (!(byten == 0 && bitn == 1) && guard < 5000) begin @(negedge clk); guard++; end
        while (scl_bus && guard < 5000) begin @(negedge clk); guard++; end
        while (!scl_bus && guard < 5000) begin @(negedge clk); guard++; end
        cnt = 0;
        while (scl_bus && guard < 5000) begin @(negedge clk); cnt++; guard++; end
        while (!scl_bus && guard < 5000) begin @(negedge clk); cnt++; guard++; end
        chk(cnt == 12, "R10 bit period 4*(div+1)", cnt, 12);
        while (!(byten == 1 && bitn == 3) && guard < 5000) begin @(negedge clk); guard++; end
        ctl_wr = 1'b1; ctl_en = 1'b0;
        @(negedge clk); ctl_wr = 1'b0;
        chk(!master_en, "R6 enable clears at once", master_en, 0);
        chk(stops == s0, "R6 no STOP inside the byte", stops - s0, 0);
        while (stops == s0 && guard < 8000) begin @(negedge clk); guard++; end
        chk(got_n == 2 && got[1] == 8'hA5, "R6 byte finished before STOP", {got_n[7:0], got[1]}, 16'h02A5);
        repeat (10) @(negedge clk);

        // R7 rival master wins on the first address bit (a one)
        s0 = stops; guard = 0;
        start_xfer(7'h40, 1'b0);
        while (!(byten == 0 && bitn == 0 && !scl_bus) && guard < 5000) begin @(negedge clk); guard++; end
        rival_lo = 1'b1;
        while (!arb_lost && guard < 5000) begin @(negedge clk); guard++; end
        chk(arb_lost, "R7 loss flagged", arb_lost, 1);
        chk(!scl_lo && !sda_lo, "R7 lines released with flag", {scl_lo, sda_lo}, 0);
        chk(!master_en, "R7 enable cleared", master_en, 0);
        repeat (100) @(negedge clk);
        chk(!scl_lo && !sda_lo && stops == s0, "R7 no STOP after loss", {scl_lo, sda_lo, 1'(stops - s0)}, 0);
        rival_lo = 1'b0;
        repeat (20) @(negedge clk);

        // R9 reset keeps the check flag
        run_xfer(7'h5C, 1'b1, 2, 15, 1'b1, 1'b1, 8'h77);
        chk(crc_err, "R8 bad check byte sets flag", crc_err, 1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(crc_err, "R9 reset leaves check flag", crc_err, 1);
        chk(!master_en && !dir_q, "R9 reset clears direction", {master_en, dir_q}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule